// File: doc/BRIEF.md
# Physical-Layer Status Word with Cross-Cleared Latches

This block assembles one read-only 16-bit status word for a management register file, where it sits at address 0x10. It takes raw event and condition signals from the physical-layer logic and holds them in a mix of live copies, latch-high bits that remember an event, and latch-low bits that remember a loss. A latched event bit is not cleared by reading this word. Each one is cleared by a read of the companion register that holds the detail for that event, such as a counter or an interrupt cause.

The block sees only the strobe and the 5-bit address of each management read. Register framing, the counters and the negotiation logic are outside it. Every bit is registered, so an input change shows in the word one clock later. A clearing read in cycle T takes effect at the end of T.

Top module: `link_stat_reg`

## Requirements
- R1: While reset is asserted, and at the first cycle after it, the status word is 0x0000.
- R2: Bit 15 and bits 5 to 0 always read 0.
- R3: Bit 14 equals the pair-swap input (1 = swapped) as it was sampled at the previous clock edge.
- R4: Each latch-high bit is set on the clock edge after its event input is 1. It then holds 1 until its clearing read. The event bits are 13 (receive error), 12 (inverted polarity), 11 (false carrier), 8 (page received), 7 (interrupt pending) and 6 (remote fault).
- R5: A read with strobe high clears a latch-high bit on the next edge, as follows. Address 0x15 clears bit 13. Address 0x1A clears bit 12. Address 0x14 clears bit 11. Address 0x06 clears bit 8. Address 0x12 clears bit 7. Address 0x01 clears bit 6.
- R6: A read of address 0x10 does not clear any latch-high bit.
- R7: If an event and its clearing read arrive in the same cycle, the bit is 1 after that edge.
- R8: Bits 10 (signal detect) and 9 (descrambler lock) are latch-low. Whenever the input is 0 at an edge, the bit is 0 after that edge. Once 0, the bit stays 0 until a read of 0x10, even if the input returns to 1.
- R9: A read of 0x10 loads each latch-low bit with its input value in that cycle. After reset, a latch-low bit reads 0 until the first such read.
- R10: An address that is present while the strobe is 0 clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Management read strobe |
| rd_addr | input | 5 | Address of the management read |
| mdix_swap | input | 1 | Live pair-swap state, 1 = swapped |
| rx_err_evt | input | 1 | Receive error event |
| pol_inv_det | input | 1 | Inverted polarity detected |
| false_car_evt | input | 1 | False carrier event |
| sig_det | input | 1 | Live signal detect |
| descr_lock | input | 1 | Live descrambler lock |
| page_rx_evt | input | 1 | Page received flag |
| irq_evt | input | 1 | Interrupt pending source |
| rem_fault_evt | input | 1 | Remote fault notice from link partner |
| status | output | 16 | Assembled status word |

## Verification
Two functions can fall in the same cycle: an event that sets a bit, and the read of that bit's clearing address. For the latch-low bits the matching pair is a drop of the input during a read of 0x10. The bench drives each pair together on purpose. A behavioural reference model, in which the event always wins, judges the outcome. The same model also judges a long random phase in which events, drops and reads of every relevant address overlap freely.

// File: rtl/link_stat_reg.sv
module link_stat_reg #(
  parameter int AW = 5,
  parameter logic [AW-1:0] A_SELF  = 'h10,
  parameter logic [AW-1:0] A_RXERR = 'h15,
  parameter logic [AW-1:0] A_POL   = 'h1A,
  parameter logic [AW-1:0] A_FCAR  = 'h14,
  parameter logic [AW-1:0] A_ANEXP = 'h06,
  parameter logic [AW-1:0] A_IRQ   = 'h12,
  parameter logic [AW-1:0] A_BSTAT = 'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic          mdix_swap,
  input  logic          rx_err_evt,
  input  logic          pol_inv_det,
  input  logic          false_car_evt,
  input  logic          sig_det,
  input  logic          descr_lock,
  input  logic          page_rx_evt,
  input  logic          irq_evt,
  input  logic          rem_fault_evt,
  output logic [15:0]   status
);
  logic [5:0] hi_evt, hi_clr, hi_q;
  logic [1:0] lo_live, lo_q;
  logic       lo_clr, mdix_q;

  assign hi_evt = {rx_err_evt, pol_inv_det, false_car_evt, page_rx_evt, irq_evt, rem_fault_evt};
  assign hi_clr = {6{rd_stb}} & {rd_addr == A_RXERR, rd_addr == A_POL, rd_addr == A_FCAR,
                                 rd_addr == A_ANEXP, rd_addr == A_IRQ, rd_addr == A_BSTAT};
  assign lo_live = {sig_det, descr_lock};
  assign lo_clr  = rd_stb && (rd_addr == A_SELF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      mdix_q <= 1'b0;
    end else begin
      hi_q   <= hi_evt | (hi_q & ~hi_clr);
      lo_q   <= lo_clr ? lo_live : (lo_q & lo_live);
      mdix_q <= mdix_swap;
    end
  end

  assign status = {1'b0, mdix_q, hi_q[5:3], lo_q, hi_q[2:0], 6'b0};
endmodule

// File: rtl/link_stat_chk.sv
module link_stat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_stb,
  input logic [4:0]  rd_addr,
  input logic        mdix_swap,
  input logic        rx_err_evt,
  input logic        pol_inv_det,
  input logic        false_car_evt,
  input logic        sig_det,
  input logic        descr_lock,
  input logic        page_rx_evt,
  input logic        irq_evt,
  input logic        rem_fault_evt,
  input logic [15:0] status
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[15] == 1'b0 && status[5:0] == 6'b0);
  assert_mirror_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mdix_swap |=> status[14]);
  assert_mirror_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mdix_swap |=> !status[14]);
  assert_rxerr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_evt |=> status[13]);
  assert_pol_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pol_inv_det |=> status[12]);
  assert_fcar_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    false_car_evt |=> status[11]);
  assert_page_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    page_rx_evt |=> status[8]);
  assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> status[7]);
  assert_rfault_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rem_fault_evt |=> status[6]);
  assert_rxerr_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_addr == 5'h15 && !rx_err_evt |=> !status[13]);
  assert_irq_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_addr == 5'h12 && !irq_evt |=> !status[7]);
  assert_rfault_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_addr == 5'h01 && !rem_fault_evt |=> !status[6]);
  assert_self_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_addr == 5'h10 && status[13] |=> status[13]);
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    false_car_evt && rd_stb && rd_addr == 5'h14 |=> status[11]);
  assert_low_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_det |=> !status[10]);
  assert_low_stuck_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !status[9] && !(rd_stb && rd_addr == 5'h10) |=> !status[9]);
  assert_low_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_addr == 5'h10 && descr_lock |=> status[9]);
  assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb && !page_rx_evt && status[8] |=> status[8]);
endmodule

bind link_stat_reg link_stat_chk u_chk (.*);

// File: tb/sim_link_stat_reg.sv
module sim_link_stat_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rst_n = 1'b0, rd_stb = 1'b0;
  logic [4:0] rd_addr = '0;
  logic mdix_swap = 0, rx_err_evt = 0, pol_inv_det = 0, false_car_evt = 0;
  logic sig_det = 0, descr_lock = 0, page_rx_evt = 0, irq_evt = 0, rem_fault_evt = 0;
  logic [15:0] status;

  int checks = 0, errs = 0, cycles = 0;
  string tag = "R1";
  logic [15:0] exp_w = '0;
  int hpos [6] = '{13, 12, 11, 8, 7, 6};
  int hadr [6] = '{'h15, 'h1A, 'h14, 'h06, 'h12, 'h01};

  link_stat_reg u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errs++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
      $finish;
    end
  end

  function automatic logic [5:0] evts();
    return {rx_err_evt, pol_inv_det, false_car_evt, page_rx_evt, irq_evt, rem_fault_evt};
  endfunction

  task automatic model_step();
    logic [5:0] e = evts();
    bit self_rd = rd_stb && rd_addr == 5'h10;
    logic [15:0] n = '0;
    for (int i = 0; i < 6; i++) begin
      bit hit = rd_stb && (int'(rd_addr) == hadr[i]);
      n[hpos[i]] = e[5-i] || (exp_w[hpos[i]] && !hit);
    end
    n[10] = self_rd ? sig_det    : (exp_w[10] && sig_det);
    n[9]  = self_rd ? descr_lock : (exp_w[9]  && descr_lock);
    n[14] = mdix_swap;
    exp_w = n;
  endtask

  task automatic compare();
    checks++;
    if (status !== exp_w) begin
      errs++;
      $display("FAIL %s: status=%04h expected=%04h", tag, status, exp_w);
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic rd(input logic [4:0] a);
    rd_stb = 1; rd_addr = a; tick(); rd_stb = 0;
  endtask

  task automatic clear_events();
    rx_err_evt = 0; pol_inv_det = 0; false_car_evt = 0;
    page_rx_evt = 0; irq_evt = 0; rem_fault_evt = 0;
  endtask

  task automatic pulse(input int i);
    case (i)
      0: rx_err_evt = 1; 1: pol_inv_det = 1; 2: false_car_evt = 1;
      3: page_rx_evt = 1; 4: irq_evt = 1; default: rem_fault_evt = 1;
    endcase
    tick();
    clear_events();
  endtask

  initial begin
    sig_det = 1; descr_lock = 1; mdix_swap = 1; rx_err_evt = 1;
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1;
    clear_events(); mdix_swap = 0;
    tick();

    tag = "R3";
    mdix_swap = 1; tick(); tick(); mdix_swap = 0; tick(); mdix_swap = 1; tick();

    for (int i = 0; i < 6; i++) begin
      tag = "R4";  pulse(i); tick(); tick();
      tag = "R6";  rd(5'h10);
      tag = "R10"; rd_stb = 0; rd_addr = 5'(hadr[i]); tick();
      tag = "R5";  rd(5'(hadr[i])); tick();
      tag = "R7";  rx_err_evt = (i == 0); pol_inv_det = (i == 1); false_car_evt = (i == 2);
                   page_rx_evt = (i == 3); irq_evt = (i == 4); rem_fault_evt = (i == 5);
                   rd(5'(hadr[i])); clear_events(); tick();
      tag = "R5";  rd(5'(hadr[i]));
    end

    tag = "R9"; tick(); rd(5'h10); tick();
    tag = "R8"; sig_det = 0; tick(); sig_det = 1; tick(); tick();
    descr_lock = 0; tick(); descr_lock = 1; tick();
    tag = "R6"; rd(5'h15); tick();
    tag = "R9"; rd(5'h10); tick();
    tag = "R7"; sig_det = 0; rd(5'h10); sig_det = 1; tick();
    tag = "R10"; rd_addr = 5'h10; tick(); rd(5'h10);

    tag = "R2";
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r = $urandom();
      rx_err_evt = r[3:0] == 0; pol_inv_det = r[7:4] == 0; false_car_evt = r[11:8] == 0;
      page_rx_evt = r[15:12] == 0; irq_evt = r[19:16] == 0; rem_fault_evt = r[23:20] == 0;
      sig_det = r[26:24] != 0; descr_lock = r[29:27] != 0; mdix_swap = r[30];
      rd_stb = r[31] | r[2];
      case (r[22:20] ^ r[10:8])
        0: rd_addr = 5'h10; 1: rd_addr = 5'h15; 2: rd_addr = 5'h1A; 3: rd_addr = 5'h14;
        4: rd_addr = 5'h06; 5: rd_addr = 5'h12; 6: rd_addr = 5'h01; default: rd_addr = r[4:0];
      endcase
      tick();
    end
    rd_stb = 0; clear_events(); tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
    $finish;
  end
endmodule